// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It combines the accumulator operand and a second operand under a 4-bit operation code and produces the 8-bit result in the same cycle. It also produces the next value of the four arithmetic flags (negative, overflow, zero, carry) and a mask that shows which of those flags the operation writes. The carry input feeds the add, subtract and rotate operations.

A status register inside the block holds the flags at their fixed bit positions. When `flag_we` is high at a clock edge, the register loads the flags that the operation writes. The other bits of the register keep their values. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Operation codes: 0 add with carry, 1 subtract with borrow, 2 AND, 3 OR, 4 XOR, 5 compare, 6 bit test, 7 increment, 8 decrement, 9 shift left, 10 shift right, 11 rotate left, 12 rotate right. Codes 13 to 15 are reserved.

Top module: `alu8_core`

## Requirements
- R1: Code 0 gives A+B+Cin modulo 256 and writes N, V, Z and C (mask 4'b1111, bit order N V Z C from bit 3 down to bit 0). C is the carry out of bit 7. V is set when A and B have the same sign and the result sign differs from it.
- R2: Code 1 gives A-B-(1-Cin) modulo 256 and writes all four flags. C=1 means no borrow occurred. V uses the same sign test as R1, applied to A and the inverted B.
- R3: Codes 2, 3 and 4 give A&B, A|B and A^B. They write only N (result bit 7) and Z (mask 4'b1010). The flag outputs for V and C equal the stored V and C.
- R4: Code 5 compares A with B. The result output equals A. N is bit 7 of A-B, Z=(A==B), C=(A>=B) unsigned, and V is not written (mask 4'b1011).
- R5: Code 6 is the bit test. The result output equals A. Z=((A&B)==0), N=B[7] and V=B[6]. C is not written (mask 4'b1110).
- R6: Codes 7 and 8 give A+1 and A-1 modulo 256. They write only N and Z (mask 4'b1010).
- R7: Code 9 shifts A left, puts a 0 into bit 0 and moves old bit 7 into C. Code 10 shifts A right, puts a 0 into bit 7, moves old bit 0 into C and so always clears N. Both use mask 4'b1011.
- R8: Code 11 rotates left, with Cin going into bit 0 and old bit 7 going into C. Code 12 rotates right, with Cin going into bit 7 and old bit 0 going into C. Both use mask 4'b1011.
- R9: Reserved codes 13 to 15 pass A to the result and write no flag (mask 0).
- R10: The next-flag outputs of flags outside the mask equal the stored flags. The status output has N at bit 7, V at bit 6, Z at bit 1, C at bit 0, and all other bits 0. On a clock edge with `flag_we` high, the status register loads the next flags. With `flag_we` low it keeps its value.
- R11: While `rst_n` is low, the status output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry for add, subtract and rotate |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Status register load enable |
| result | output | 8 | Operation result |
| flag_n | output | 1 | Next negative flag |
| flag_v | output | 1 | Next overflow flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| flag_mask | output | 4 | Flags written by the operation, bit order N V Z C |
| status | output | 8 | Stored status register |

## Verification
The assertions check the following on every cycle:
- The status register holds its value when `flag_we` is low, and loads the next flags when `flag_we` is high.
- Compare and bit test leave the result equal to A, and bit test takes N and V from the operand bits.
- The logical right shift always clears N.
- The logic operations pass the stored V and C through unchanged.
- Reserved codes write no flag.
- Z tracks a zero result wherever Z is taken from the result.

Only the bench's scenarios can show that the arithmetic values themselves are right. These are the overflow and borrow edges around 0x7F, 0x80 and 0xFF, the carry-in paths of add, subtract and rotate, and the way masked updates accumulate in the status register over long mixed sequences.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  // operation codes; values 13..15 are reserved
  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_AND = 4'd2,
    OP_ORA = 4'd3,
    OP_EOR = 4'd4,
    OP_CMP = 4'd5,
    OP_BIT = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8,
    OP_ASL = 4'd9,
    OP_LSR = 4'd10,
    OP_ROL = 4'd11,
    OP_ROR = 4'd12
  } alu_op_e;

  // index of each flag inside the 4-bit flag / mask vectors
  localparam int FI_N = 3;
  localparam int FI_V = 2;
  localparam int FI_Z = 1;
  localparam int FI_C = 0;
  localparam int NFLAG = 4;

  // position of each flag inside the status register
  localparam int SP_N = 7;
  localparam int SP_V = 6;
  localparam int SP_Z = 1;
  localparam int SP_C = 0;

  // write masks, bit order N V Z C
  localparam logic [NFLAG-1:0] MSK_ALL  = 4'b1111;
  localparam logic [NFLAG-1:0] MSK_NZ   = 4'b1010;
  localparam logic [NFLAG-1:0] MSK_NZC  = 4'b1011;
  localparam logic [NFLAG-1:0] MSK_NVZ  = 4'b1110;
  localparam logic [NFLAG-1:0] MSK_NONE = 4'b0000;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic              cin,
  output logic [DW-1:0]     res,
  output logic [NFLAG-1:0]  flg,
  output logic [NFLAG-1:0]  msk
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] addend;
  logic          c_use;
  logic [DW:0]   sum;

  // operand and carry select for the shared adder
  always_comb begin
    addend = '0;
    c_use  = 1'b0;
    msk    = MSK_NONE;
    case (op)
      OP_ADC: begin addend = b;       c_use = cin;  msk = MSK_ALL; end
      OP_SBC: begin addend = ~b;      c_use = cin;  msk = MSK_ALL; end
      OP_CMP: begin addend = ~b;      c_use = 1'b1; msk = MSK_NZC; end
      OP_INC: begin addend = '0;      c_use = 1'b1; msk = MSK_NZ;  end
      OP_DEC: begin addend = '1;      c_use = 1'b0; msk = MSK_NZ;  end
      default: begin addend = '0;     c_use = 1'b0; msk = MSK_NONE; end
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, addend} + {{DW{1'b0}}, c_use};

  // compare leaves the accumulator value on the result
  assign res = (op == OP_CMP) ? a : sum[DW-1:0];

  always_comb begin
    flg       = '0;
    flg[FI_N] = sum[MSB];
    flg[FI_Z] = (sum[DW-1:0] == '0);
    flg[FI_C] = sum[DW];
    flg[FI_V] = (a[MSB] == addend[MSB]) && (sum[MSB] != a[MSB]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  output logic [DW-1:0]     res,
  output logic [NFLAG-1:0]  flg,
  output logic [NFLAG-1:0]  msk
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] bitwise;
  logic          is_test;

  always_comb begin
    case (op)
      OP_ORA:  bitwise = a | b;
      OP_EOR:  bitwise = a ^ b;
      default: bitwise = a & b;
    endcase
  end

  assign is_test = (op == OP_BIT);
  assign res     = is_test ? a : bitwise;
  assign msk     = is_test ? MSK_NVZ : MSK_NZ;

  always_comb begin
    flg       = '0;
    flg[FI_Z] = (bitwise == '0);
    flg[FI_N] = is_test ? b[MSB] : bitwise[MSB];
    flg[FI_V] = b[MSB-1];
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic              cin,
  output logic [DW-1:0]     res,
  output logic [NFLAG-1:0]  flg,
  output logic [NFLAG-1:0]  msk
);

  localparam int MSB = DW - 1;

  logic          go_left;
  logic          fill_lo;
  logic          fill_hi;
  logic [DW-1:0] up;
  logic [DW-1:0] down;

  assign go_left = (op == OP_ASL) || (op == OP_ROL);
  assign fill_lo = (op == OP_ROL) ? cin : 1'b0;
  assign fill_hi = (op == OP_ROR) ? cin : 1'b0;

  // one lane per bit: neighbour or fill value
  for (genvar i = 0; i < DW; i++) begin : g_lane
    if (i == 0) begin : g_lo
      assign up[i] = fill_lo;
    end else begin : g_lo
      assign up[i] = a[i-1];
    end
    if (i == MSB) begin : g_hi
      assign down[i] = fill_hi;
    end else begin : g_hi
      assign down[i] = a[i+1];
    end
  end

  assign res = go_left ? up : down;
  assign msk = MSK_NZC;

  always_comb begin
    flg       = '0;
    flg[FI_N] = res[MSB];
    flg[FI_Z] = (res == '0);
    flg[FI_C] = go_left ? a[MSB] : a[0];
  end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NFLAG-1:0]  nvzc,
  output logic [SW-1:0]     stat_q
);

  logic [SW-1:0] stat_d;

  // next-state: scatter flags to their register positions
  always_comb begin
    stat_d       = '0;
    stat_d[SP_N] = nvzc[FI_N];
    stat_d[SP_V] = nvzc[FI_V];
    stat_d[SP_Z] = nvzc[FI_Z];
    stat_d[SP_C] = nvzc[FI_C];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (we) begin
      stat_q <= stat_d;
    end
  end

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(stat_q));

  // R10
  stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (stat_q[SP_N] == $past(nvzc[FI_N])) && (stat_q[SP_V] == $past(nvzc[FI_V]))
        && (stat_q[SP_Z] == $past(nvzc[FI_Z])) && (stat_q[SP_C] == $past(nvzc[FI_C])));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     opnd_a,
  input  logic [DW-1:0]     opnd_b,
  input  logic              carry_in,
  input  logic [3:0]        op_sel,
  input  logic              flag_we,
  output logic [DW-1:0]     result,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_c,
  output logic [NFLAG-1:0]  flag_mask,
  output logic [SW-1:0]     status
);

  localparam int MSB = DW - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  // functional units
  logic [DW-1:0]    ar_res, lg_res, sh_res;
  logic [NFLAG-1:0] ar_flg, lg_flg, sh_flg;
  logic [NFLAG-1:0] ar_msk, lg_msk, sh_msk;

  alu8_arith #(.DW(DW)) u_arith (
    .op (op), .a (opnd_a), .b (opnd_b), .cin (carry_in),
    .res (ar_res), .flg (ar_flg), .msk (ar_msk)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op (op), .a (opnd_a), .b (opnd_b),
    .res (lg_res), .flg (lg_flg), .msk (lg_msk)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .op (op), .a (opnd_a), .cin (carry_in),
    .res (sh_res), .flg (sh_flg), .msk (sh_msk)
  );

  // unit select
  logic [DW-1:0]    sel_res;
  logic [NFLAG-1:0] sel_flg;
  logic [NFLAG-1:0] sel_msk;

  always_comb begin
    case (op)
      OP_ADC, OP_SBC, OP_CMP, OP_INC, OP_DEC: begin
        sel_res = ar_res; sel_flg = ar_flg; sel_msk = ar_msk;
      end
      OP_AND, OP_ORA, OP_EOR, OP_BIT: begin
        sel_res = lg_res; sel_flg = lg_flg; sel_msk = lg_msk;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        sel_res = sh_res; sel_flg = sh_flg; sel_msk = sh_msk;
      end
      default: begin
        sel_res = opnd_a; sel_flg = '0; sel_msk = MSK_NONE;
      end
    endcase
  end

  // merge written flags with the stored ones
  logic [NFLAG-1:0] stored;
  logic [NFLAG-1:0] nvzc_nxt;

  assign stored   = {status[SP_N], status[SP_V], status[SP_Z], status[SP_C]};
  assign nvzc_nxt = (sel_flg & sel_msk) | (stored & ~sel_msk);

  alu8_status #(.SW(SW)) u_status (
    .clk (clk), .rst_n (rst_int_n), .we (flag_we),
    .nvzc (nvzc_nxt), .stat_q (status)
  );

  assign result    = sel_res;
  assign flag_mask = sel_msk;
  assign flag_n    = nvzc_nxt[FI_N];
  assign flag_v    = nvzc_nxt[FI_V];
  assign flag_z    = nvzc_nxt[FI_Z];
  assign flag_c    = nvzc_nxt[FI_C];

  // R3
  logic_vc_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_AND || op == OP_ORA || op == OP_EOR)
      |-> (flag_v == status[SP_V]) && (flag_c == status[SP_C]));

  // R4
  cmp_keeps_a_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_CMP) |-> (result == opnd_a) && (flag_v == status[SP_V]));

  // R5
  bit_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_BIT) |-> (result == opnd_a) && (flag_n == opnd_b[MSB]) && (flag_v == opnd_b[MSB-1]));

  // R7
  lsr_n_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op == OP_LSR) |-> !flag_n);

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_sel > 4'd12) |-> (flag_mask == '0) && (result == opnd_a) && (flag_c == status[SP_C]));

  // R6
  zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_sel <= 4'd12 && op != OP_CMP && op != OP_BIT) |-> (flag_z == (result == '0)));

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] opnd_a, opnd_b;
  logic       carry_in;
  logic [3:0] op_sel;
  logic       flag_we;
  logic [7:0] result;
  logic       flag_n, flag_v, flag_z, flag_c;
  logic [3:0] flag_mask;
  logic [7:0] status;

  int  n_checks = 0;
  int  n_err    = 0;
  bit  done     = 0;

  always #4 clk = ~clk;

  alu8_core u_dut (
    .clk (clk), .rst_n (rst_n), .opnd_a (opnd_a), .opnd_b (opnd_b),
    .carry_in (carry_in), .op_sel (op_sel), .flag_we (flag_we),
    .result (result), .flag_n (flag_n), .flag_v (flag_v), .flag_z (flag_z),
    .flag_c (flag_c), .flag_mask (flag_mask), .status (status)
  );

  typedef struct {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic       we;
  } item_t;

  item_t q[$];
  item_t it;
  logic [3:0] exp_nvzc = 4'b0000;

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%b act=%h exp=%h",
               req, it.op, it.a, it.b, it.cin, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0:                req_of = "R1";
      4'd1:                req_of = "R2";
      4'd2, 4'd3, 4'd4:    req_of = "R3";
      4'd5:                req_of = "R4";
      4'd6:                req_of = "R5";
      4'd7, 4'd8:          req_of = "R6";
      4'd9, 4'd10:         req_of = "R7";
      4'd11, 4'd12:        req_of = "R8";
      default:             req_of = "R9";
    endcase
  endfunction

  // reference model: {result, N V Z C, mask}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic cin);
    int s;
    logic [7:0] r;
    logic n, v, z, c;
    logic [3:0] m;
    r = a; n = 0; v = 0; z = 0; c = 0; m = 4'b0000; s = 0;
    case (op)
      4'd0: begin
        s = int'(a) + int'(b) + int'(cin);
        r = s[7:0]; c = (s > 255); v = (((a ^ r) & (b ^ r) & 8'h80) != 0); m = 4'b1111;
      end
      4'd1: begin
        s = int'(a) - int'(b) - (cin ? 0 : 1);
        r = s[7:0]; c = (s >= 0); v = (((a ^ b) & (a ^ r) & 8'h80) != 0); m = 4'b1111;
      end
      4'd2: begin r = a & b; m = 4'b1010; end
      4'd3: begin r = a | b; m = 4'b1010; end
      4'd4: begin r = a ^ b; m = 4'b1010; end
      4'd5: begin
        s = int'(a) - int'(b);
        n = s[7]; z = (a == b); c = (a >= b); r = a; m = 4'b1011;
      end
      4'd6: begin z = ((a & b) == 8'h00); n = b[7]; v = b[6]; r = a; m = 4'b1110; end
      4'd7: begin r = a + 8'd1; m = 4'b1010; end
      4'd8: begin r = a - 8'd1; m = 4'b1010; end
      4'd9:  begin r = {a[6:0], 1'b0}; c = a[7]; m = 4'b1011; end
      4'd10: begin r = {1'b0, a[7:1]}; c = a[0]; m = 4'b1011; end
      4'd11: begin r = {a[6:0], cin};  c = a[7]; m = 4'b1011; end
      4'd12: begin r = {cin, a[7:1]};  c = a[0]; m = 4'b1011; end
      default: begin r = a; m = 4'b0000; end
    endcase
    if (op != 4'd5 && op != 4'd6 && op <= 4'd12) begin
      n = r[7];
      z = (r == 8'h00);
    end
    model = {r, n, v, z, c, m};
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cin, input logic we);
    item_t x;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = cin; flag_we = we;
    x.op = op; x.a = a; x.b = b; x.cin = cin; x.we = we;
    q.push_back(x);
  endtask

  // monitor: compare one item per cycle, after the edge that loads it
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      logic [15:0] mr;
      logic [3:0]  nxt;
      logic [7:0]  exp_stat;
      it  = q.pop_front();
      mr  = model(it.op, it.a, it.b, it.cin);
      nxt = (mr[7:4] & mr[3:0]) | (exp_nvzc & ~mr[3:0]);
      check(result == mr[15:8], req_of(it.op), {8'h00, result}, {8'h00, mr[15:8]});
      check(flag_mask == mr[3:0], req_of(it.op), {12'h000, flag_mask}, {12'h000, mr[3:0]});
      check({flag_n, flag_v, flag_z, flag_c} == nxt, req_of(it.op),
            {12'h000, flag_n, flag_v, flag_z, flag_c}, {12'h000, nxt});
      if (it.we) exp_nvzc = nxt;
      exp_stat = {exp_nvzc[3], exp_nvzc[2], 4'b0000, exp_nvzc[1], exp_nvzc[0]};
      // R10 stored flags at their positions, held when the enable is low
      check(status == exp_stat, "R10", {8'h00, status}, {8'h00, exp_stat});
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1..all act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    opnd_a = 8'hFF; opnd_b = 8'h01; carry_in = 1'b1; op_sel = 4'd0; flag_we = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R11 status cleared while reset is held, even with the enable high
    check(status == 8'h00, "R11", {8'h00, status}, 16'h0000);
    @(negedge clk);
    flag_we = 1'b0;
    rst_n   = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    // R10 enable low after release: register keeps its reset value
    check(status == 8'h00, "R10", {8'h00, status}, 16'h0000);

    for (int op = 0; op <= 12; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 19; bi++) begin
          logic [7:0] b;
          if (bi < 16)       b = 8'(bi * 17);
          else if (bi == 16) b = 8'h80;
          else if (bi == 17) b = 8'h7F;
          else               b = 8'h01;
          for (int c = 0; c < 2; c++) begin
            drive(4'(op), 8'(a), b, c[0], ((a ^ bi ^ c) & 3) != 0);
          end
        end
      end
    end
    // R9 reserved codes
    for (int op = 13; op <= 15; op++) begin
      for (int a = 0; a < 256; a++) begin
        drive(4'(op), 8'(a), 8'(~a), a[0], 1'b1);
      end
    end

    @(negedge clk);
    flag_we = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule